// File: doc/BRIEF.md
# Page-Buffered Memory Programming Controller

This controller sits behind a serial programming front end. It models two non-volatile arrays: a flash array that is written one whole page at a time, and a byte-wide EEPROM. Flash data is first collected in a page buffer, one 16-bit word at a time, and the low byte of each word must arrive before its high byte. A commit command then names the target page, and after a parameterised number of cycles the whole buffer lands in that page at once. An EEPROM write erases its location at once and stores the new byte when its own timed interval ends.

A host learns when a write is finished by reading back the location it wrote. While a page write runs, every byte of that page reads 0xFF. While an EEPROM write runs, the location being written reads 0xFF. The true value appears as soon as the write ends. A value of 0xFF looks the same as an erased cell, so a host that writes 0xFF must wait out the full write time. Any command that would change state while a write is running is rejected and flagged, never silently taken. The `busy` output lets a bench follow the write timers directly. A chip-erase command returns both arrays and the page buffer to 0xFF.

Top module: `nvm_prog_ctrl`

## Requirements
- R1: After reset `busy` is 0, `cmd_err` is 0, `rd_data` is 0xFF, and every flash and EEPROM location reads 0xFF.
- R2: Command codes on `cmd_op` are: 0 chip erase, 1 load low byte, 2 load high byte, 3 commit page, 4 read flash low byte, 5 read flash high byte, 6 write EEPROM byte, 7 read EEPROM byte. Loads use `cmd_addr[5:0]` as the buffer word index. A commit uses `cmd_addr[3:0]` as the page number and, when its write ends, replaces every word of that page with the buffer; other pages are left unchanged. Flash reads take the address {page, word} from `cmd_addr[9:0]`.
- R3: A high-byte load is accepted only if a low-byte load for the same word index was accepted since the last commit or erase. Otherwise the high-byte load raises `cmd_err` and stores nothing.
- R4: When a page write ends, every buffer byte returns to 0xFF and no word counts as having its low byte loaded.
- R5: While a page write runs, a flash read of any byte of that page returns 0xFF. Reads of other pages return stored data.
- R6: An EEPROM write (address `cmd_addr[5:0]`) makes that location read 0xFF from acceptance until the write ends. After that the location holds exactly the new byte, with nothing of the old value left.
- R7: While `busy` is 1, commands 0, 1, 2, 3 and 6 raise `cmd_err` for one cycle and change nothing. Read commands never raise `cmd_err`.
- R8: An accepted chip erase sets all flash and EEPROM bytes and the page buffer to 0xFF, and forgets all loaded low bytes.
- R9: `busy` rises on the edge that accepts a commit or EEPROM write. It stays high for exactly FL_CYCLES or EE_CYCLES cycles respectively. At most one write runs at a time.
- R10: `rd_data` changes only on the edge after a read command and holds its value otherwise. `cmd_err` appears on the edge after the offending command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Command code |
| cmd_addr | input | 10 | Word index, page number or byte address, depending on the command |
| cmd_data | input | 8 | Byte to load or write |
| rd_data | output | 8 | Registered read result |
| busy | output | 1 | A timed write is in progress |
| cmd_err | output | 1 | Previous command was rejected |

## Verification
The assertions watch the properties that hold on every cycle. Flash and EEPROM writes never overlap. A modifying command issued while busy always produces an error. A poll of the page or byte being written always returns 0xFF. Every accepted write raises `busy`. `rd_data` stays still when no read is issued. Other behaviour only shows up in the bench's command sequences: the stored values after a commit, the low-before-high ordering, the buffer being refilled with 0xFF, full replacement on EEPROM rewrites, chip-erase effects, and exact busy durations.

// File: rtl/nvm_prog_ctrl.sv
module nvm_prog_ctrl #(
  parameter int WORD_IDX_W = 6,
  parameter int PAGE_SEL_W = 4,
  parameter int EE_ADDR_W  = 6,
  parameter int FL_CYCLES  = 40,
  parameter int EE_CYCLES  = 20,
  localparam int FL_ADDR_W = PAGE_SEL_W + WORD_IDX_W,
  localparam int ADDR_W    = (FL_ADDR_W > EE_ADDR_W) ? FL_ADDR_W : EE_ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [7:0]        cmd_data,
  output logic [7:0]        rd_data,
  output logic              busy,
  output logic              cmd_err
);
  localparam int PAGE_WORDS = 1 << WORD_IDX_W;
  localparam int FL_BYTES   = 2 << FL_ADDR_W;
  localparam int EE_BYTES   = 1 << EE_ADDR_W;
  localparam int MAX_CYC    = (FL_CYCLES > EE_CYCLES) ? FL_CYCLES : EE_CYCLES;
  localparam int CNT_W      = $clog2(MAX_CYC + 1);

  localparam logic [2:0] OP_ERASE = 3'd0, OP_LD_LO = 3'd1, OP_LD_HI = 3'd2, OP_COMMIT = 3'd3,
                         OP_RD_LO = 3'd4, OP_RD_HI = 3'd5, OP_EE_WR = 3'd6, OP_EE_RD = 3'd7;

  logic [7:0] fl_mem [FL_BYTES];
  logic [7:0] ee_mem [EE_BYTES];
  logic [7:0] buf_lo [PAGE_WORDS];
  logic [7:0] buf_hi [PAGE_WORDS];
  logic [PAGE_WORDS-1:0] lo_pend;

  logic                  fl_busy, ee_busy;
  logic [CNT_W-1:0]      cnt;
  logic [PAGE_SEL_W-1:0] wr_page;
  logic [EE_ADDR_W-1:0]  ee_wa;
  logic [7:0]            ee_wd;

  wire [WORD_IDX_W-1:0] widx    = cmd_addr[WORD_IDX_W-1:0];
  wire [PAGE_SEL_W-1:0] psel    = cmd_addr[PAGE_SEL_W-1:0];
  wire [FL_ADDR_W-1:0]  fl_a    = cmd_addr[FL_ADDR_W-1:0];
  wire [EE_ADDR_W-1:0]  ee_a    = cmd_addr[EE_ADDR_W-1:0];
  wire                  rd_fl   = cmd_valid && (cmd_op == OP_RD_LO || cmd_op == OP_RD_HI);
  wire                  rd_any  = rd_fl || (cmd_valid && cmd_op == OP_EE_RD);
  wire                  is_mod  = cmd_valid && !rd_any;
  wire                  hi_bad  = cmd_valid && cmd_op == OP_LD_HI && !lo_pend[widx];
  wire                  accept  = is_mod && !busy && !hi_bad;
  wire                  fl_done = fl_busy && cnt == '0;
  wire                  ee_done = ee_busy && cnt == '0;
  wire                  erase   = accept && cmd_op == OP_ERASE;

  assign busy = fl_busy | ee_busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fl_busy <= 1'b0;
      ee_busy <= 1'b0;
      cnt     <= '0;
      wr_page <= '0;
      ee_wa   <= '0;
      ee_wd   <= 8'hFF;
      cmd_err <= 1'b0;
      rd_data <= 8'hFF;
    end else begin
      cmd_err <= is_mod && (busy || hi_bad);
      if (accept && cmd_op == OP_COMMIT) begin
        fl_busy <= 1'b1;
        cnt     <= CNT_W'(FL_CYCLES - 1);
        wr_page <= psel;
      end else if (accept && cmd_op == OP_EE_WR) begin
        ee_busy <= 1'b1;
        cnt     <= CNT_W'(EE_CYCLES - 1);
        ee_wa   <= ee_a;
        ee_wd   <= cmd_data;
      end else if (busy) begin
        if (cnt == '0) begin
          fl_busy <= 1'b0;
          ee_busy <= 1'b0;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
      if (rd_fl) begin
        if (fl_busy && fl_a[FL_ADDR_W-1 -: PAGE_SEL_W] == wr_page)
          rd_data <= 8'hFF;
        else
          rd_data <= fl_mem[{fl_a, cmd_op == OP_RD_HI}];
      end else if (rd_any) begin
        rd_data <= ee_mem[ee_a];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || erase) begin
      for (int i = 0; i < FL_BYTES; i++) fl_mem[i] <= 8'hFF;
      for (int i = 0; i < EE_BYTES; i++) ee_mem[i] <= 8'hFF;
      for (int i = 0; i < PAGE_WORDS; i++) begin
        buf_lo[i] <= 8'hFF;
        buf_hi[i] <= 8'hFF;
      end
      lo_pend <= '0;
    end else begin
      if (fl_done) begin
        for (int i = 0; i < PAGE_WORDS; i++) begin
          fl_mem[{wr_page, WORD_IDX_W'(i), 1'b0}] <= buf_lo[i];
          fl_mem[{wr_page, WORD_IDX_W'(i), 1'b1}] <= buf_hi[i];
          buf_lo[i] <= 8'hFF;
          buf_hi[i] <= 8'hFF;
        end
        lo_pend <= '0;
      end
      if (ee_done) ee_mem[ee_wa] <= ee_wd;
      if (accept) begin
        case (cmd_op)
          OP_LD_LO: begin
            buf_lo[widx]  <= cmd_data;
            lo_pend[widx] <= 1'b1;
          end
          OP_LD_HI: begin
            buf_hi[widx]  <= cmd_data;
            lo_pend[widx] <= 1'b0;
          end
          OP_EE_WR: ee_mem[ee_a] <= 8'hFF;
          default: ;
        endcase
      end
    end
  end

  // R9
  single_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fl_busy, ee_busy}));
  // R9
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && (cmd_op == OP_COMMIT || cmd_op == OP_EE_WR) |=> busy);
  // R7
  busy_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_mod && busy |=> cmd_err);
  // R5
  page_poll_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fl && fl_busy && fl_a[FL_ADDR_W-1 -: PAGE_SEL_W] == wr_page |=> rd_data == 8'hFF);
  // R6
  ee_poll_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == OP_EE_RD && ee_busy && ee_a == ee_wa |=> rd_data == 8'hFF);
  // R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_any |=> $stable(rd_data));
  // R7
  read_noerr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_any |=> !cmd_err);
endmodule

// File: tb/nvm_prog_ctrl_bench.sv
module nvm_prog_ctrl_bench;
  localparam int FLC = 40, EEC = 20;
  localparam logic [3:0] ER = 0, LL = 1, LH = 2, WP = 3, RL = 4, RH = 5, WE = 6, RE = 7, WT = 15;

  typedef struct packed {
    logic [3:0] op; logic [9:0] addr; logic [7:0] data;
    logic chk; logic [7:0] exp; logic err; logic [3:0] req;
  } vec_t;

  localparam int NV = 52;
  localparam vec_t VEC [NV] = '{
    '{RL, 10'd0,   8'h00, 1'b1, 8'hFF, 1'b0, 4'd1},  // R1 erased at reset
    '{LL, 10'd0,   8'hC3, 1'b0, 8'h00, 1'b0, 4'd2},  // R2
    '{LH, 10'd0,   8'h3C, 1'b0, 8'h00, 1'b0, 4'd2},
    '{WP, 10'd1,   8'h00, 1'b0, 8'h00, 1'b0, 4'd2},
    '{WT, 10'd0,   8'h00, 1'b0, 8'h00, 1'b0, 4'd9},
    '{RL, 10'd64,  8'h00, 1'b1, 8'hC3, 1'b0, 4'd2},
    '{RH, 10'd64,  8'h00, 1'b1, 8'h3C, 1'b0, 4'd2},
    '{LL, 10'd5,   8'h12, 1'b0, 8'h00, 1'b0, 4'd2},
    '{LH, 10'd5,   8'h34, 1'b0, 8'h00, 1'b0, 4'd3},
    '{LH, 10'd6,   8'h56, 1'b0, 8'h00, 1'b1, 4'd3},  // R3 high before low
    '{LL, 10'd6,   8'h78, 1'b0, 8'h00, 1'b0, 4'd2},
    '{WP, 10'd2,   8'h00, 1'b0, 8'h00, 1'b0, 4'd2},
    '{RL, 10'd133, 8'h00, 1'b1, 8'hFF, 1'b0, 4'd5},  // R5 poll busy page
    '{RH, 10'd64,  8'h00, 1'b1, 8'h3C, 1'b0, 4'd5},  // R5 other page readable
    '{LL, 10'd7,   8'h99, 1'b0, 8'h00, 1'b1, 4'd7},  // R7
    '{WE, 10'd0,   8'h01, 1'b0, 8'h00, 1'b1, 4'd7},
    '{WT, 10'd0,   8'h00, 1'b0, 8'h00, 1'b0, 4'd9},
    '{RL, 10'd133, 8'h00, 1'b1, 8'h12, 1'b0, 4'd2},
    '{RH, 10'd133, 8'h00, 1'b1, 8'h34, 1'b0, 4'd2},
    '{RL, 10'd134, 8'h00, 1'b1, 8'h78, 1'b0, 4'd2},
    '{RH, 10'd134, 8'h00, 1'b1, 8'hFF, 1'b0, 4'd3},  // R3 rejected high byte absent
    '{RL, 10'd135, 8'h00, 1'b1, 8'hFF, 1'b0, 4'd7},  // R7 rejected load absent
    '{WP, 10'd2,   8'h00, 1'b0, 8'h00, 1'b0, 4'd4},
    '{WT, 10'd0,   8'h00, 1'b0, 8'h00, 1'b0, 4'd9},
    '{RL, 10'd133, 8'h00, 1'b1, 8'hFF, 1'b0, 4'd4},  // R4 buffer refilled
    '{RH, 10'd64,  8'h00, 1'b1, 8'h3C, 1'b0, 4'd2},
    '{WE, 10'd4,   8'h11, 1'b0, 8'h00, 1'b0, 4'd6},
    '{WT, 10'd0,   8'h00, 1'b0, 8'h00, 1'b0, 4'd9},
    '{WE, 10'd3,   8'hA5, 1'b0, 8'h00, 1'b0, 4'd6},
    '{RE, 10'd3,   8'h00, 1'b1, 8'hFF, 1'b0, 4'd6},  // R6 poll
    '{RE, 10'd4,   8'h00, 1'b1, 8'h11, 1'b0, 4'd6},
    '{WP, 10'd0,   8'h00, 1'b0, 8'h00, 1'b1, 4'd7},
    '{WE, 10'd3,   8'h00, 1'b0, 8'h00, 1'b1, 4'd7},
    '{WT, 10'd0,   8'h00, 1'b0, 8'h00, 1'b0, 4'd9},
    '{RE, 10'd3,   8'h00, 1'b1, 8'hA5, 1'b0, 4'd6},
    '{WE, 10'd3,   8'h5A, 1'b0, 8'h00, 1'b0, 4'd6},
    '{WT, 10'd0,   8'h00, 1'b0, 8'h00, 1'b0, 4'd9},
    '{RE, 10'd3,   8'h00, 1'b1, 8'h5A, 1'b0, 4'd6},  // R6 full replace
    '{RL, 10'd0,   8'h00, 1'b1, 8'hFF, 1'b0, 4'd7},
    '{LL, 10'd9,   8'h77, 1'b0, 8'h00, 1'b0, 4'd8},
    '{ER, 10'd0,   8'h00, 1'b0, 8'h00, 1'b0, 4'd8},  // R8
    '{RE, 10'd3,   8'h00, 1'b1, 8'hFF, 1'b0, 4'd8},
    '{RL, 10'd64,  8'h00, 1'b1, 8'hFF, 1'b0, 4'd8},
    '{RE, 10'd4,   8'h00, 1'b1, 8'hFF, 1'b0, 4'd8},
    '{WP, 10'd5,   8'h00, 1'b0, 8'h00, 1'b0, 4'd8},
    '{WT, 10'd0,   8'h00, 1'b0, 8'h00, 1'b0, 4'd9},
    '{RL, 10'd329, 8'h00, 1'b1, 8'hFF, 1'b0, 4'd8},
    '{LH, 10'd9,   8'h01, 1'b0, 8'h00, 1'b1, 4'd8},
    '{WE, 10'd1,   8'h22, 1'b0, 8'h00, 1'b0, 4'd6},
    '{ER, 10'd0,   8'h00, 1'b0, 8'h00, 1'b1, 4'd7},
    '{WT, 10'd0,   8'h00, 1'b0, 8'h00, 1'b0, 4'd9},
    '{RE, 10'd1,   8'h00, 1'b1, 8'h22, 1'b0, 4'd7}
  };

  logic clk = 0, rst_n = 0, cmd_valid = 0, busy, cmd_err;
  logic [2:0] cmd_op = 0;
  logic [9:0] cmd_addr = 0;
  logic [7:0] cmd_data = 0, rd_data;
  int tests = 0, fails = 0;

  always #10 clk = ~clk;

  nvm_prog_ctrl #(.FL_CYCLES(FLC), .EE_CYCLES(EEC)) u_nvm_prog_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .rd_data(rd_data),
    .busy(busy), .cmd_err(cmd_err));

  task automatic check(input int req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL R%0d: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] op, input logic [9:0] a, input logic [7:0] d);
    @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_addr = a; cmd_data = d;
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: got hang expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    check(1, busy, 0);
    check(1, cmd_err, 0);
    check(1, rd_data, 8'hFF);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].op == WT) wait_idle();
      else begin
        issue(VEC[i].op[2:0], VEC[i].addr, VEC[i].data);
        check(VEC[i].req, cmd_err, VEC[i].err);  // R7 / R10 error timing
        if (VEC[i].chk) check(VEC[i].req, rd_data, VEC[i].exp);
      end
    end

    // R9 flash write duration
    begin
      int n = 1;
      issue(WP[2:0], 10'd6, 8'h00);
      check(9, busy, 1);
      forever begin
        @(negedge clk);
        if (!busy) break;
        n++;
      end
      check(9, n, FLC);
    end
    // R9 EEPROM write duration
    begin
      int n = 1;
      issue(WE[2:0], 10'd8, 8'h3E);
      check(9, busy, 1);
      forever begin
        @(negedge clk);
        if (!busy) break;
        n++;
      end
      check(9, n, EEC);
    end
    // R10 rd_data holds across a non-read command
    issue(RE[2:0], 10'd8, 8'h00);
    check(10, rd_data, 8'h3E);
    issue(LL[2:0], 10'd2, 8'h44);
    check(10, rd_data, 8'h3E);

    // R1 reset in the middle of a write
    issue(WE[2:0], 10'd8, 8'h01);
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    check(1, busy, 0);
    check(1, rd_data, 8'hFF);
    issue(RE[2:0], 10'd8, 8'h00);
    check(1, rd_data, 8'hFF);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule